// File: doc/BRIEF.md
# Pulse Width Measurement Capture Timer

This block times the interval between qualifying transitions on external input lines. A single up-counter advances once for every count-clock enable pulse while a software-controlled run bit is set. When a selected transition arrives on a capture line, the counter's current value is latched into that line's capture register. The counter then restarts from zero and a one-cycle capture interrupt is raised. Each captured value is therefore the width of one pulse, measured in count-clock periods.

If no transition arrives before the counter passes its all-ones value, the counter wraps to zero and keeps running. A one-cycle overflow interrupt is raised, and a sticky overflow flag is set that software clears with a strobe. Software can rebuild a long pulse as (2^CNT_W times the number of overflows plus the captured value) times the count-clock period. Capture lines are asynchronous and are synchronized inside the block. Each line has its own transition selector, capture register and capture interrupt. All lines share the one counter.

Top module: `pw_capture_timer`

## Requirements
- R1: After synchronous active-high reset the count, every capture register and the overflow flag read zero, and no interrupt is active.
- R2: While the run bit is low, the count reads zero after one clock and nothing is captured or flagged. Capture registers and the overflow flag keep their values. Transitions seen while stopped are discarded.
- R3: While running, the count advances by one on each clock where the count-clock enable is high, and holds on every other clock.
- R4: Each line's 2-bit selector picks the qualifying transition: 2'b00 none, 2'b01 low-to-high, 2'b10 high-to-low, 2'b11 either. Channel c uses selector bits [2c+1:2c].
- R5: A qualifying transition taken on a count-clock enable stores the current count in that line's capture register and restarts the count at zero. The line's capture interrupt is high for exactly one clock, and the register changes at no other time.
- R6: A qualifying transition detected on a clock without a count-clock enable is held pending. It is captured on the next count-clock enable.
- R7: When the count is all ones and a count-clock enable arrives with no capture, the count goes to zero and keeps counting. The overflow interrupt is high for that one clock.
- R8: An overflow sets the overflow flag. The flag stays set until a clear strobe arrives. When a set and a clear fall on the same clock, the flag ends up set.
- R9: When a capture and the all-ones wrap fall on the same count-clock enable, the capture register receives all ones and the count goes to zero. Both interrupts fire and the overflow flag is set.
- R10: The capture lines work independently: a capture on one line leaves the other line's register unchanged. A capture on any line restarts the shared count.
- R11: Each capture line passes through a two-flop synchronizer. With the count-clock enable high on every clock, a transition applied just after the clock edge at which the count reads P is captured with the value P+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count-clock enable, one system clock wide per count |
| run_i | input | 1 | Run bit; low stops the timer and holds the count at zero |
| cap_in_i | input | NUM_CH | Asynchronous capture lines |
| edge_sel_i | input | 2*NUM_CH | Per-line transition selectors, two bits per line |
| flag_clr_i | input | 1 | Clear strobe for the overflow flag |
| count_o | output | CNT_W | Current count |
| cap_val_o | output | NUM_CH*CNT_W | Capture registers; line c occupies bits [c*CNT_W +: CNT_W] |
| cap_irq_o | output | NUM_CH | Capture interrupt pulses, one per line |
| ovf_irq_o | output | 1 | Overflow interrupt pulse |
| ovf_flag_o | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with CNT_W = 8 and two capture lines. With 8 bits the all-ones wrap comes every 256 count clocks. The directed wrap tests and the random run therefore reach overflow many times, including the case where a capture lands on the wrap clock. The random run sparsely gates the count-clock enable, so transitions are often detected between counts. This exercises the pending path and the independence of the two lines under mixed selector settings.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_mode_e;

    typedef struct packed {
        logic fire;
        logic pend;
    } edge_state_t;

    typedef struct packed {
        logic restart;
        logic wrap;
        logic step;
    } cnt_ctl_t;

    function automatic logic edge_match(edge_mode_e mode, logic cur, logic prev);
        logic rise;
        logic fall;
        rise = cur & ~prev;
        fall = ~cur & prev;
        case (mode)
            EDGE_RISE: edge_match = rise;
            EDGE_FALL: edge_match = fall;
            EDGE_ANY:  edge_match = rise | fall;
            default:   edge_match = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pwc_edge_unit.sv
module pwc_edge_unit
    import pwc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run_i,
    input  logic       tick_i,
    input  logic       pin_i,
    input  edge_mode_e mode_i,
    output logic       fire_o
);

    localparam int MSB = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    edge_state_t            st_q;
    edge_state_t            st_d;
    logic                   seen;

    always_comb begin
        seen       = edge_match(mode_i, sync_q[MSB], prev_q) | st_q.pend;
        st_d.fire  = run_i & tick_i & seen;
        st_d.pend  = run_i & ~tick_i & seen;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
            st_q   <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            prev_q <= sync_q[MSB];
            st_q   <= st_d;
        end
    end

    assign fire_o = st_d.fire;

    AST_PEND_DROP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> !st_q.pend) else $error("pending survived stop"); // R2
    AST_PEND_FIRES: assert property (@(posedge clk) disable iff (rst)
        (st_q.pend && run_i && tick_i) |-> fire_o) else $error("pending edge lost"); // R6

endmodule

// File: rtl/pwc_counter.sv
module pwc_counter
    import pwc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             restart_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    cnt_ctl_t         ctl;

    always_comb begin
        ctl.wrap    = run_i & tick_i & (cnt_q == CNT_MAX);
        ctl.restart = run_i & tick_i & restart_i;
        ctl.step    = run_i & tick_i & ~ctl.wrap & ~ctl.restart;
    end

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (ctl.wrap || ctl.restart) begin
            cnt_q <= '0;
        end else if (ctl.step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = ctl.wrap;

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> cnt_q == '0) else $error("count not parked"); // R2
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (run_i && tick_i && !restart_i && cnt_q != CNT_MAX) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1))
        else $error("count step wrong"); // R3
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (run_i && !tick_i) |=> $stable(cnt_q)) else $error("count moved without tick"); // R3
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (run_i && tick_i && cnt_q == CNT_MAX) |=> cnt_q == '0) else $error("wrap not to zero"); // R7

endmodule

// File: rtl/pwc_capture_reg.sv
module pwc_capture_reg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] cap_o,
    output logic             irq_o
);

    logic [CNT_W-1:0] cap_q;
    logic             irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= fire_i;
            if (fire_i) begin
                cap_q <= cnt_i;
            end
        end
    end

    assign cap_o = cap_q;
    assign irq_o = irq_q;

    AST_CAP_LOAD: assert property (@(posedge clk) disable iff (rst)
        fire_i |=> (cap_q == $past(cnt_i)) && irq_q) else $error("capture load wrong"); // R5
    AST_CAP_KEEP: assert property (@(posedge clk) disable iff (rst)
        !fire_i |=> $stable(cap_q) && !irq_q) else $error("capture changed unprompted"); // R5

endmodule

// File: rtl/pw_capture_timer.sv
module pw_capture_timer
    import pwc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int NUM_CH      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick_i,
    input  logic                    run_i,
    input  logic [NUM_CH-1:0]       cap_in_i,
    input  logic [2*NUM_CH-1:0]     edge_sel_i,
    input  logic                    flag_clr_i,
    output logic [CNT_W-1:0]        count_o,
    output logic [NUM_CH*CNT_W-1:0] cap_val_o,
    output logic [NUM_CH-1:0]       cap_irq_o,
    output logic                    ovf_irq_o,
    output logic                    ovf_flag_o
);

    logic [NUM_CH-1:0] fire;
    logic [CNT_W-1:0]  cnt;
    logic              wrap;
    logic              any_fire;
    logic              ovf_irq_q;
    logic              ovf_flag_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwc_edge_unit #(
            .SYNC_STAGES (SYNC_STAGES)
        ) u_edge (
            .clk    (clk),
            .rst    (rst),
            .run_i  (run_i),
            .tick_i (tick_i),
            .pin_i  (cap_in_i[c]),
            .mode_i (edge_mode_e'(edge_sel_i[2*c +: 2])),
            .fire_o (fire[c])
        );

        pwc_capture_reg #(
            .CNT_W (CNT_W)
        ) u_cap (
            .clk    (clk),
            .rst    (rst),
            .fire_i (fire[c]),
            .cnt_i  (cnt),
            .cap_o  (cap_val_o[c*CNT_W +: CNT_W]),
            .irq_o  (cap_irq_o[c])
        );
    end

    assign any_fire = |fire;

    pwc_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .run_i     (run_i),
        .tick_i    (tick_i),
        .restart_i (any_fire),
        .cnt_o     (cnt),
        .wrap_o    (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_irq_q  <= 1'b0;
            ovf_flag_q <= 1'b0;
        end else begin
            ovf_irq_q <= wrap;
            if (wrap) begin
                ovf_flag_q <= 1'b1;
            end else if (flag_clr_i) begin
                ovf_flag_q <= 1'b0;
            end
        end
    end

    assign count_o    = cnt;
    assign ovf_irq_o  = ovf_irq_q;
    assign ovf_flag_o = ovf_flag_q;

    AST_OVF_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        ovf_irq_o |-> ovf_flag_o) else $error("overflow without flag"); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag_o && !flag_clr_i) |=> ovf_flag_o) else $error("flag lost"); // R8
    AST_CAP_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        (any_fire) |=> count_o == '0) else $error("capture did not restart count"); // R5
    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (cap_irq_o == '0) && !ovf_irq_o) else $error("interrupt while stopped"); // R2

endmodule

// File: tb/tb_pw_capture_timer.sv
module tb_pw_capture_timer;

    localparam int W   = 8;
    localparam int NCH = 2;
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic             clk = 1'b0;
    logic             rst;
    logic             tick;
    logic             run;
    logic [NCH-1:0]   cin;
    logic [2*NCH-1:0] sel;
    logic             clr;
    logic [W-1:0]     count_o;
    logic [NCH*W-1:0] cap_val_o;
    logic [NCH-1:0]   cap_irq_o;
    logic             ovf_irq_o;
    logic             ovf_flag_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pw_capture_timer #(.CNT_W(W), .NUM_CH(NCH), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .tick_i(tick), .run_i(run), .cap_in_i(cin),
        .edge_sel_i(sel), .flag_clr_i(clr), .count_o(count_o), .cap_val_o(cap_val_o),
        .cap_irq_o(cap_irq_o), .ovf_irq_o(ovf_irq_o), .ovf_flag_o(ovf_flag_o)
    );

    function automatic logic exp_edge(logic [1:0] s, logic cur, logic prev);
        case (s)
            2'b01:   return cur & ~prev;
            2'b10:   return ~cur & prev;
            2'b11:   return cur ^ prev;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [W-1:0] cap_of(int c);
        return cap_val_o[c*W +: W];
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference model of the requirements
    logic         m_s1 [NCH];
    logic         m_s2 [NCH];
    logic         m_pv [NCH];
    logic         m_pd [NCH];
    logic [W-1:0] m_cap [NCH];
    logic         m_ci [NCH];
    logic [W-1:0] m_cnt;
    logic         m_oi;
    logic         m_fl;
    logic         cmp_en = 1'b0;

    always @(posedge clk) begin
        logic any;
        logic wr;
        logic hit;
        if (rst) begin
            for (int c = 0; c < NCH; c++) begin
                m_s1[c] <= 0; m_s2[c] <= 0; m_pv[c] <= 0; m_pd[c] <= 0;
                m_cap[c] <= '0; m_ci[c] <= 0;
            end
            m_cnt <= '0; m_oi <= 0; m_fl <= 0;
        end else begin
            any = 1'b0;
            wr  = run && tick && (m_cnt == MAXV);
            for (int c = 0; c < NCH; c++) begin
                hit = exp_edge(sel[2*c +: 2], m_s2[c], m_pv[c]) | m_pd[c];
                m_s1[c] <= cin[c];
                m_s2[c] <= m_s1[c];
                m_pv[c] <= m_s2[c];
                m_pd[c] <= run && !tick && hit;
                m_ci[c] <= run && tick && hit;
                if (run && tick && hit) begin
                    m_cap[c] <= m_cnt;
                    any = 1'b1;
                end
            end
            m_oi <= wr;
            if (wr) m_fl <= 1'b1;
            else if (clr) m_fl <= 1'b0;
            if (!run) m_cnt <= '0;
            else if (tick) m_cnt <= (any || wr) ? '0 : m_cnt + 1'b1;
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            check("R3", "model count", int'(count_o), int'(m_cnt));
            for (int c = 0; c < NCH; c++) begin
                check("R5", "model capture value", int'(cap_of(c)), int'(m_cap[c]));
                check("R6", "model capture irq", int'(cap_irq_o[c]), int'(m_ci[c]));
            end
            check("R7", "model overflow irq", int'(ovf_irq_o), int'(m_oi));
            check("R8", "model overflow flag", int'(ovf_flag_o), int'(m_fl));
        end
    end

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_count(logic [W-1:0] v);
        while (count_o != v) @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] held;
        void'($urandom(32'd20240611));
        rst = 1; tick = 0; run = 0; cin = '0; sel = '0; clr = 0;
        cyc(3);
        rst = 0;
        cyc(1);
        // R1 reset state
        check("R1", "count after reset", int'(count_o), 0);
        check("R1", "cap0 after reset", int'(cap_of(0)), 0);
        check("R1", "cap1 after reset", int'(cap_of(1)), 0);
        check("R1", "flag after reset", int'(ovf_flag_o), 0);
        check("R1", "irqs after reset", int'({cap_irq_o, ovf_irq_o}), 0);
        cmp_en = 1'b1;

        // R11 and R5: rising capture with tick every clock
        sel = 4'b0001; tick = 1; run = 1;
        wait_count(8'd10);
        cin[0] = 1'b1;
        cyc(3);
        check("R11", "synchronized capture value", int'(cap_of(0)), 12);
        check("R5", "capture irq pulse", int'(cap_irq_o[0]), 1);
        check("R5", "count restarted", int'(count_o), 0);
        cyc(1);
        check("R5", "capture irq one clock", int'(cap_irq_o[0]), 0);
        check("R5", "count resumes", int'(count_o), 1);

        // R4: selector 00 ignores transitions; rising-only ignores a fall
        sel = 4'b0000; cin[0] = 1'b0;
        cyc(5);
        check("R4", "no capture with selector off", int'(cap_irq_o[0]), 0);
        check("R4", "cap0 unchanged selector off", int'(cap_of(0)), 12);
        check("R4", "count kept running", int'(count_o), 6);

        // R9 and R8: capture on the wrap clock with a simultaneous clear
        sel = 4'b0001;
        wait_count(MAXV - 2);
        cin[0] = 1'b1;
        cyc(2);
        clr = 1'b1;
        cyc(1);
        clr = 1'b0;
        check("R9", "capture holds all ones", int'(cap_of(0)), int'(MAXV));
        check("R9", "capture irq at wrap", int'(cap_irq_o[0]), 1);
        check("R9", "overflow irq at wrap", int'(ovf_irq_o), 1);
        check("R8", "set beats clear", int'(ovf_flag_o), 1);
        check("R9", "count zero after both", int'(count_o), 0);
        cyc(1);
        check("R7", "overflow irq one clock", int'(ovf_irq_o), 0);
        check("R8", "flag sticky", int'(ovf_flag_o), 1);
        clr = 1'b1;
        cyc(1);
        clr = 1'b0;
        check("R8", "flag cleared by strobe", int'(ovf_flag_o), 0);

        // R7: plain wrap without any edge
        wait_count(MAXV);
        cyc(1);
        check("R7", "plain wrap irq", int'(ovf_irq_o), 1);
        check("R7", "plain wrap count zero", int'(count_o), 0);
        check("R7", "plain wrap keeps cap0", int'(cap_of(0)), int'(MAXV));
        cyc(1);
        check("R7", "counting continues after wrap", int'(count_o), 1);

        // R6 and R10: falling edge on line 1 held while no tick
        sel = 4'b0001; cin[1] = 1'b1;
        tick = 0;
        cyc(4);
        held = count_o;
        sel = 4'b1001; cin[1] = 1'b0;
        cyc(6);
        check("R6", "no capture without tick", int'(cap_irq_o[1]), 0);
        check("R6", "count held without tick", int'(count_o), int'(held));
        tick = 1;
        cyc(1);
        tick = 0;
        check("R6", "pending edge captured", int'(cap_of(1)), int'(held));
        check("R10", "line1 irq", int'(cap_irq_o[1]), 1);
        check("R10", "line0 irq quiet", int'(cap_irq_o[0]), 0);
        check("R10", "line1 restarts shared count", int'(count_o), 0);
        check("R10", "line0 register untouched", int'(cap_of(0)), int'(MAXV));

        // R2: stop holds zero, edges while stopped discarded
        tick = 1;
        cyc(3);
        run = 0;
        sel = 4'b1111; cin = 2'b11;
        cyc(6);
        check("R2", "count parked", int'(count_o), 0);
        check("R2", "cap1 kept while stopped", int'(cap_of(1)), int'(held));
        check("R2", "no irq while stopped", int'(cap_irq_o), 0);
        run = 1;
        cyc(3);
        check("R2", "stopped edge discarded", int'(cap_irq_o), 0);
        check("R2", "count restarts from zero", int'(count_o), 3);

        // Random phase against the model
        for (int i = 0; i < 40000; i++) begin
            tick = ($urandom % 4) != 0;
            if (($urandom % 800) == 0) run = ~run;
            if (!run && ($urandom % 20) == 0) run = 1'b1;
            for (int c = 0; c < NCH; c++)
                if (($urandom % 180) == 0) cin[c] = ~cin[c];
            if (($urandom % 1500) == 0) sel = 4'($urandom);
            clr = ($urandom % 120) == 0;
            cyc(1);
        end

        cmp_en = 1'b0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule